// File: doc/BRIEF.md
# Programmable display clock divider tree

This block turns a fast oscillator clock into two slower timing references for a display link: a byte-rate strobe and a pixel-rate strobe. Both are single-cycle clock enables in the oscillator clock domain, so downstream logic runs on the fast clock and advances only on an enable. A tree of dividers produces them. A power-of-two first stage feeds a programmable bit divider, and the bit rate is divided by eight for the byte strobe. A four-way source select then picks the input of a programmable pixel divider. That input is one of: the bit rate, half the bit rate, the first-stage rate, or a quarter of the first-stage rate.

Software writes the divider fields through a small write-only register port. New values wait in a shadow copy. They move into the tree only once each output has finished the period it was in, and every counter then restarts together, so no strobe ever comes early. A global enable masks both strobes ahead of a power-down while the counters keep their phase.

Top module: `dispclk_divtree`

## Requirements
- R1: While reset is low both strobes are low. After reset the tree runs with first-stage exponent 0, bit divider 1, pixel divider 1 and source select 0, which gives a byte strobe every 8 cycles and a pixel strobe on every cycle.
- R2: Register address 2, bits [1:0], hold an exponent e. The first stage divides the oscillator clock by 2^e (values 0 to 3 give /1, /2, /4, /8).
- R3: Register address 0, bits [3:0], hold the one-based bit divider B. The byte strobe period is 2^e * B * 8 cycles.
- R4: Register address 0, bits [7:4], hold the one-based pixel divider D. The pixel strobe period is 2^e * S * D cycles, where S is the source factor from R5.
- R5: Register address 1, bits [1:0], pick the pixel source. Code 0 is the bit rate (S = B), 1 is half the bit rate (S = 2B), 2 is the first-stage rate (S = 1), and 3 is a quarter of the first-stage rate (S = 4).
- R6: A value of 0 in either one-based divider field divides by 1.
- R7: A write lands in a shadow copy. The copy takes effect in the first cycle at which both outputs have completed their current period. Strobes falling between an output's last old period end and that moment are suppressed. All counters restart together, and each output's first new strobe comes exactly one new period after that cycle. No strobe is ever closer to the one before it than the shorter of the old and new periods.
- R8: With the global enable low, both strobes are low from the next cycle on. The dividers keep counting, so once the enable returns the strobes appear on the same phase as before.
- R9: Each strobe is a one-cycle pulse that appears one cycle after its divider chain reaches terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all strobes are aligned to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Global strobe enable; low masks both outputs |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | AW (2) | Register address: 0 dividers, 1 pixel source, 2 first-stage exponent |
| cfg_wdata | input | DW (8) | Write data |
| byte_ce | output | 1 | Byte-rate clock enable |
| pix_ce | output | 1 | Pixel-rate clock enable |

## Verification
Every power-of-two exponent is driven with the smallest divider values, so that the first stage alone sets the byte and pixel spacing. Bit and pixel dividers are then set to odd, coprime values such as 3 and 5, so a period that lands on the wrong product or uses the wrong field shows up as a different spacing. All four source codes are tried with the same dividers, because each gives a distinct pixel period that only the intended tap can produce. Zero fields, rapid back-to-back rewrites at arbitrary phases and a gated window then separate the commit, suppression and enable paths from the plain counting path.

// File: rtl/dispclk_pkg.sv
package dispclk_pkg;

   // Pixel-divider source codes; the value is the register field encoding.
   typedef enum logic [1:0] {
      SRC_BIT      = 2'd0,
      SRC_BIT_HALF = 2'd1,
      SRC_OUT      = 2'd2,
      SRC_OUT_QTR  = 2'd3
   } pix_src_e;

   // Register addresses of the configuration port.
   localparam int unsigned REG_DIVS   = 0;
   localparam int unsigned REG_SRC    = 1;
   localparam int unsigned REG_OUTDIV = 2;

endpackage

// File: rtl/dispclk_stage.sv
// One counting stage: passes every ratio-th input tick; ratio 0 acts as 1.
module dispclk_stage #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          in_t,
   input  logic [CW-1:0] ratio,
   output logic          out_t
);

   logic [CW-1:0] eff;
   logic [CW-1:0] cnt;
   logic          last;

   assign eff   = (ratio == '0) ? CW'(1) : ratio;
   assign last  = (cnt == eff - CW'(1));
   assign out_t = in_t & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (in_t) begin
         cnt <= last ? '0 : cnt + CW'(1);
      end
   end

endmodule

// File: rtl/dispclk_cfg.sv
// Shadow and active configuration with boundary-aligned commit.
module dispclk_cfg
   import dispclk_pkg::*;
#(
   parameter int OD_W  = 2,
   parameter int DIV_W = 4,
   parameter int DW    = 8,
   parameter int AW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             byte_tick,
   input  logic             pix_tick,
   output logic [OD_W-1:0]  act_od,
   output logic [DIV_W-1:0] act_bdiv,
   output logic [DIV_W-1:0] act_pdiv,
   output pix_src_e         act_src,
   output logic             commit,
   output logic             byte_hold,
   output logic             pix_hold
);

   logic [OD_W-1:0]  pnd_od;
   logic [DIV_W-1:0] pnd_bdiv;
   logic [DIV_W-1:0] pnd_pdiv;
   pix_src_e         pnd_src;
   logic             pend;
   logic             wr_divs, wr_src, wr_od;

   assign wr_divs = we && (addr == AW'(REG_DIVS));
   assign wr_src  = we && (addr == AW'(REG_SRC));
   assign wr_od   = we && (addr == AW'(REG_OUTDIV));

   // Both outputs must sit at (or have passed) a period end.
   assign commit = pend && (byte_tick || byte_hold) && (pix_tick || pix_hold);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pnd_od   <= '0;
         pnd_bdiv <= DIV_W'(1);
         pnd_pdiv <= DIV_W'(1);
         pnd_src  <= SRC_BIT;
      end else begin
         if (wr_divs) begin
            pnd_bdiv <= wdata[DIV_W-1:0];
            pnd_pdiv <= wdata[2*DIV_W-1:DIV_W];
         end
         if (wr_src) pnd_src <= pix_src_e'(wdata[1:0]);
         if (wr_od)  pnd_od  <= wdata[OD_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_od    <= '0;
         act_bdiv  <= DIV_W'(1);
         act_pdiv  <= DIV_W'(1);
         act_src   <= SRC_BIT;
         byte_hold <= 1'b0;
         pix_hold  <= 1'b0;
      end else if (commit) begin
         act_od    <= pnd_od;
         act_bdiv  <= pnd_bdiv;
         act_pdiv  <= pnd_pdiv;
         act_src   <= pnd_src;
         byte_hold <= 1'b0;
         pix_hold  <= 1'b0;
      end else if (pend) begin
         byte_hold <= byte_hold | byte_tick;
         pix_hold  <= pix_hold | pix_tick;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend <= 1'b0;
      else if (we)     pend <= 1'b1;
      else if (commit) pend <= 1'b0;
   end

endmodule

// File: rtl/dispclk_divtree.sv
module dispclk_divtree
   import dispclk_pkg::*;
#(
   parameter int OD_W     = 2,
   parameter int DIV_W    = 4,
   parameter int DW       = 8,
   parameter int AW       = 2,
   parameter int BYTE_DIV = 8,
   parameter int HALF_DIV = 2,
   parameter int QTR_DIV  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clk_en,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic          byte_ce,
   output logic          pix_ce
);

   localparam int OD_RW   = 1 << OD_W;
   localparam int BYTE_CW = $clog2(BYTE_DIV) + 1;
   localparam int HALF_CW = $clog2(HALF_DIV) + 1;
   localparam int QTR_CW  = $clog2(QTR_DIV) + 1;

   generate
      if (DW < 2 * DIV_W) begin : g_bad_dw
         $error("cfg_wdata too narrow for both one-based divider fields");
      end
      if (AW < 2) begin : g_bad_aw
         $error("address width must reach three registers");
      end
      if (DW < OD_W) begin : g_bad_od
         $error("cfg_wdata too narrow for the first-stage exponent");
      end
      if (BYTE_DIV < 1 || HALF_DIV < 1 || QTR_DIV < 1) begin : g_bad_fix
         $error("fixed ratios must be at least one");
      end
   endgenerate

   logic [OD_W-1:0]  act_od;
   logic [DIV_W-1:0] act_bdiv, act_pdiv;
   pix_src_e         act_src;
   logic             commit, byte_hold, pix_hold;
   logic             t_out, t_bit, t_byte, t_half, t_qtr, t_pix;
   logic [3:0]       src_t;
   logic             t_src;

   dispclk_cfg #(
      .OD_W(OD_W), .DIV_W(DIV_W), .DW(DW), .AW(AW)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .byte_tick (t_byte),
      .pix_tick  (t_pix),
      .act_od    (act_od),
      .act_bdiv  (act_bdiv),
      .act_pdiv  (act_pdiv),
      .act_src   (act_src),
      .commit    (commit),
      .byte_hold (byte_hold),
      .pix_hold  (pix_hold)
   );

   // Power-of-two first stage.
   dispclk_stage #(.CW(OD_RW)) u_out (
      .clk(clk), .rst_n(rst_n), .clr(commit), .in_t(1'b1),
      .ratio(OD_RW'(1) << act_od), .out_t(t_out)
   );

   // One-based bit divider.
   dispclk_stage #(.CW(DIV_W)) u_bit (
      .clk(clk), .rst_n(rst_n), .clr(commit), .in_t(t_out),
      .ratio(act_bdiv), .out_t(t_bit)
   );

   // Fixed taps.
   dispclk_stage #(.CW(BYTE_CW)) u_byte (
      .clk(clk), .rst_n(rst_n), .clr(commit), .in_t(t_bit),
      .ratio(BYTE_CW'(BYTE_DIV)), .out_t(t_byte)
   );

   dispclk_stage #(.CW(HALF_CW)) u_half (
      .clk(clk), .rst_n(rst_n), .clr(commit), .in_t(t_bit),
      .ratio(HALF_CW'(HALF_DIV)), .out_t(t_half)
   );

   dispclk_stage #(.CW(QTR_CW)) u_qtr (
      .clk(clk), .rst_n(rst_n), .clr(commit), .in_t(t_out),
      .ratio(QTR_CW'(QTR_DIV)), .out_t(t_qtr)
   );

   // Four-way source select for the pixel divider.
   assign src_t[SRC_BIT]      = t_bit;
   assign src_t[SRC_BIT_HALF] = t_half;
   assign src_t[SRC_OUT]      = t_out;
   assign src_t[SRC_OUT_QTR]  = t_qtr;
   assign t_src               = src_t[act_src];

   dispclk_stage #(.CW(DIV_W)) u_pix (
      .clk(clk), .rst_n(rst_n), .clr(commit), .in_t(t_src),
      .ratio(act_pdiv), .out_t(t_pix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_ce <= 1'b0;
         pix_ce  <= 1'b0;
      end else begin
         byte_ce <= t_byte & ~byte_hold & clk_en;
         pix_ce  <= t_pix & ~pix_hold & clk_en;
      end
   end

endmodule

// File: rtl/dispclk_divtree_chk.sv
module dispclk_divtree_chk #(
   parameter int MIN_GAP = 8
) (
   input logic clk,
   input logic rst_n,
   input logic clk_en,
   input logic cfg_we,
   input logic byte_ce,
   input logic pix_ce
);

   logic [15:0] gap, last_gap;
   logic [2:0]  npulse;
   logic        cur_q;
   logic [1:0]  qh;
   logic        rst_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap      <= '0;
         last_gap <= '0;
         npulse   <= '0;
         cur_q    <= 1'b0;
         qh       <= '0;
      end else if (byte_ce) begin
         gap      <= 16'd1;
         last_gap <= gap;
         if (npulse != 3'd7) npulse <= npulse + 3'd1;
         qh       <= {qh[0], cur_q};
         cur_q    <= !cfg_we && clk_en;
      end else begin
         if (gap != 16'hFFFF) gap <= gap + 16'd1;
         cur_q <= cur_q & !cfg_we & clk_en;
      end
   end

   always_ff @(posedge clk) begin
      rst_seen <= !rst_n;
   end

   always @(posedge clk) begin
      if (!rst_n && rst_seen) begin
         AST_RESET_QUIET: assert (!byte_ce && !pix_ce); // R1
      end
   end

   AST_BYTE_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ce && npulse != 3'd0) |-> gap >= 16'(MIN_GAP)); // R3

   AST_BYTE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_ce && npulse >= 3'd3 && qh == 2'b11 && cur_q) |-> gap == last_gap); // R7

   AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> (!byte_ce && !pix_ce)); // R8

   AST_BYTE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ce |=> !byte_ce); // R9

endmodule

bind dispclk_divtree dispclk_divtree_chk #(.MIN_GAP(BYTE_DIV)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clk_en  (clk_en),
   .cfg_we  (cfg_we),
   .byte_ce (byte_ce),
   .pix_ce  (pix_ce)
);

// File: tb/dispclk_divtree_test.sv
`timescale 1ns/1ps
module dispclk_divtree_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       byte_ce, pix_ce;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   bit    run_cmp = 0;
   string cur_tag = "R1";

   always #5 clk = ~clk;

   dispclk_divtree uut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .byte_ce(byte_ce), .pix_ce(pix_ce)
   );

   // ---------------- reference model ----------------
   function automatic int one_based(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int byte_period(input int od, input int bd);
      return (1 << od) * one_based(bd) * 8;
   endfunction

   function automatic int pix_period(input int od, input int bd, input int pd, input int sel);
      int s;
      case (sel)
         0: s = one_based(bd);
         1: s = 2 * one_based(bd);
         2: s = 1;
         default: s = 4;
      endcase
      return (1 << od) * s * one_based(pd);
   endfunction

   int a_od, a_bd, a_pd, a_sel, p_od, p_bd, p_pd, p_sel;
   int ph_b, ph_p, per_b, per_p;
   bit pend, hold_b, hold_p, exp_b, exp_p;
   bit tk_b, tk_p, cm;

   always @(posedge clk) begin
      if (!rst_n) begin
         a_od = 0; a_bd = 1; a_pd = 1; a_sel = 0;
         p_od = 0; p_bd = 1; p_pd = 1; p_sel = 0;
         ph_b = 0; ph_p = 0; pend = 0; hold_b = 0; hold_p = 0;
         exp_b = 0; exp_p = 0;
      end else begin
         per_b = byte_period(a_od, a_bd);
         per_p = pix_period(a_od, a_bd, a_pd, a_sel);
         tk_b  = (ph_b == per_b - 1);
         tk_p  = (ph_p == per_p - 1);
         exp_b = tk_b && !hold_b && clk_en;
         exp_p = tk_p && !hold_p && clk_en;
         cm    = pend && (tk_b || hold_b) && (tk_p || hold_p);
         if (cm) begin
            a_od = p_od; a_bd = p_bd; a_pd = p_pd; a_sel = p_sel;
            ph_b = 0; ph_p = 0; hold_b = 0; hold_p = 0; pend = 0;
         end else begin
            ph_b = tk_b ? 0 : ph_b + 1;
            ph_p = tk_p ? 0 : ph_p + 1;
            if (pend) begin
               hold_b = hold_b | tk_b;
               hold_p = hold_p | tk_p;
            end
         end
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: begin p_bd = cfg_wdata[3:0]; p_pd = cfg_wdata[7:4]; end
               2'd1: p_sel = cfg_wdata[1:0];
               2'd2: p_od = cfg_wdata[1:0];
               default: ;
            endcase
            pend = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && run_cmp && !done) begin
         n_tests++;
         if (byte_ce !== exp_b) begin
            n_fail++;
            $display("FAIL %s byte_ce actual=%b expected=%b at %0t", cur_tag, byte_ce, exp_b, $time);
         end
         n_tests++;
         if (pix_ce !== exp_p) begin
            n_fail++;
            $display("FAIL %s pix_ce actual=%b expected=%b at %0t", cur_tag, pix_ce, exp_p, $time);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic wr(input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 8'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic settle();
      repeat (700) @(negedge clk);
   endtask

   function automatic logic pick(input int which);
      return (which == 0) ? byte_ce : pix_ce;
   endfunction

   task automatic gap_check(input string tag, input int which, input int expv);
      int n;
      do @(negedge clk); while (pick(which) !== 1'b1);
      n = 0;
      do begin @(negedge clk); n++; end while (pick(which) !== 1'b1);
      n_tests++;
      if (n != expv) begin
         n_fail++;
         $display("FAIL %s %s gap actual=%0d expected=%0d", tag, which == 0 ? "byte" : "pixel", n, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired, run did not complete");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      n_tests++;
      if (byte_ce !== 1'b0 || pix_ce !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 outputs in reset actual=%b%b expected=00", byte_ce, pix_ce);
      end
      rst_n = 1'b1;
      run_cmp = 1;

      cur_tag = "R1";
      gap_check("R1", 0, 8);
      gap_check("R1", 1, 1);

      cur_tag = "R2";
      wr(2, 2); settle();
      gap_check("R2", 0, byte_period(2, 1));
      gap_check("R2", 1, pix_period(2, 1, 1, 0));
      wr(2, 3); settle();
      gap_check("R2", 0, byte_period(3, 1));
      wr(2, 1); settle();
      gap_check("R2", 1, pix_period(1, 1, 1, 0));

      cur_tag = "R3";
      wr(2, 0); wr(0, 8'h13); settle();
      gap_check("R3", 0, byte_period(0, 3));
      gap_check("R3", 1, pix_period(0, 3, 1, 0));

      cur_tag = "R4";
      wr(0, 8'h53); settle();
      gap_check("R4", 1, pix_period(0, 3, 5, 0));
      gap_check("R4", 0, byte_period(0, 3));

      cur_tag = "R5";
      wr(1, 1); settle();
      gap_check("R5", 1, pix_period(0, 3, 5, 1));
      wr(1, 2); settle();
      gap_check("R5", 1, pix_period(0, 3, 5, 2));
      wr(1, 3); settle();
      gap_check("R5", 1, pix_period(0, 3, 5, 3));

      cur_tag = "R6";
      wr(0, 8'h00); settle();
      gap_check("R6", 0, byte_period(0, 0));
      gap_check("R6", 1, pix_period(0, 0, 0, 3));

      cur_tag = "R7";
      wr(2, 1); wr(0, 8'h37); wr(1, 1); settle();
      gap_check("R7", 0, byte_period(1, 7));
      gap_check("R7", 1, pix_period(1, 7, 3, 1));
      for (int i = 0; i < 6; i++) begin
         repeat (23 + 17 * i) @(negedge clk);
         wr(i % 3, (i * 37 + 5) & 8'h33);
      end
      settle();
      wr(2, 0); repeat (5) @(negedge clk); wr(0, 8'h21); wr(1, 0);
      settle();
      gap_check("R7", 0, byte_period(0, 1));
      gap_check("R7", 1, pix_period(0, 1, 2, 0));

      cur_tag = "R8";
      wr(0, 8'h32); settle();
      @(negedge clk); clk_en = 1'b0;
      cnt = 0;
      repeat (200) begin
         @(negedge clk);
         if (byte_ce || pix_ce) cnt++;
      end
      n_tests++;
      if (cnt != 0) begin
         n_fail++;
         $display("FAIL R8 strobes while gated actual=%0d expected=0", cnt);
      end
      clk_en = 1'b1;
      repeat (300) @(negedge clk);
      gap_check("R8", 0, byte_period(0, 2));

      cur_tag = "R9";
      gap_check("R9", 1, pix_period(0, 2, 3, 0));
      do @(negedge clk); while (byte_ce !== 1'b1);
      @(negedge clk);
      n_tests++;
      if (byte_ce !== 1'b0) begin
         n_fail++;
         $display("FAIL R9 byte strobe width actual=%b expected=0 on second cycle", byte_ce);
      end

      repeat (20) @(negedge clk);
      finish_run();
   end

endmodule